// File: doc/BRIEF.md
# Checksummed Serial Control Loader

This block receives 72-bit configuration frames over a three-wire serial link (data, shift clock, frame strobe). The shift clock and the strobe come from a slow, unrelated source, so they are brought into the system clock domain through synchronizer flops. Edges are then detected in that domain. Each bit is taken on a rising edge of the shift clock, lowest bit first. When the strobe rises, the frame is checked:

- the bit count must be exactly 72;
- an 8-bit chip identifier must match;
- a category byte must name one of two register banks;
- the byte-wise sum of all nine bytes must be zero, unless a bypass input is high.

An accepted frame is held as a pending update. Its 56 payload bits are written to the selected bank only at a falling edge of horizontal sync that occurs while the current line is the readout line. No write happens while a long multi-field exposure is running. Three control-bank bits, the two power-state bits and the internal-sync enable, are exempt from this deferral. They take effect on the strobe rise itself. The outputs are both active banks and a one-cycle pulse for each accepted frame.

Top module: `serial_cfg_loader`

## Requirements
- R1: Bits are captured on rising shift-clock edges while the strobe is low, and the first bit sent becomes frame bit 0. At the strobe rising edge the frame is evaluated only if exactly 72 bits were captured since the strobe fell. A frame of 71 or 73 bits changes no bank and raises no accept pulse.
- R2: A frame is accepted only if frame bits 7..0 equal 8'h81.
- R3: Frame bits 15..8 equal to 8'h00 select the control bank, and 8'h01 selects the adjustment bank. Any other value rejects the frame. Frame bits 71..16 form the 56-bit payload, and payload bit k is frame bit k+16.
- R4: Bits 71..64 carry a checksum. A frame is accepted only if the sum of its nine bytes (bits 8i+7..8i) is zero modulo 256.
- R5: While `cksum_bypass` is high, the checksum test is skipped and all other tests still apply.
- R6: An accepted frame does not change the bank it names at the strobe rise, apart from R7. The payload is written at the next falling edge of `hsync` seen while `readout_line` is high. A falling edge with `readout_line` low writes nothing.
- R7: For a control-bank frame, payload bits 36, 46 and 47 are copied into the control bank at the strobe rise. Later payload bits are not copied at that point.
- R8: Only one pending update exists at a time. A second accepted frame for the same bank replaces the pending payload. A frame for the other bank while an update is pending is rejected, with no accept pulse.
- R9: While `long_expose` is high, no pending update is written to a bank. The write happens at the first qualifying `hsync` fall after `long_expose` goes low.
- R10: Reset clears both banks and any pending update. `load_ok` is high for exactly one cycle per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; bits are taken on its rising edge |
| ser_strobe | input | 1 | Frame strobe; low while shifting, rising edge ends the frame |
| cksum_bypass | input | 1 | High skips the checksum test |
| hsync | input | 1 | Horizontal sync; falling edge is the write point |
| readout_line | input | 1 | High during the readout line (system clock domain) |
| long_expose | input | 1 | High while a multi-field exposure blocks writes |
| ctrl_bank | output | 56 | Active control bank |
| adj_bank | output | 56 | Active adjustment bank |
| load_ok | output | 1 | One-cycle pulse per accepted frame |

## Verification
The frame tests use well-formed frames for each bank and then single faults: a wrong identifier, an unknown category, a corrupted checksum (sent with and without bypass) and bit counts one short and one long. Each case shows which single test blocks acceptance. Payloads with and without the three immediate bits set separate the strobe-time path from the deferred path. Sync falls outside the readout line and during a long exposure show that the write waits for the right edge. Back-to-back frames to the same bank and to the other bank show the replace and lock rules of the pending buffer.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int FRAME_BITS  = 72;
    localparam int BYTE_W      = 8;
    localparam int NUM_BYTES   = FRAME_BITS / BYTE_W;
    localparam int PAYLOAD_LSB = 16;
    localparam int PAYLOAD_W   = FRAME_BITS - PAYLOAD_LSB;
    localparam int CNT_W       = $clog2(FRAME_BITS + 2);

    localparam logic [BYTE_W-1:0] CAT_CTRL = 8'h00;
    localparam logic [BYTE_W-1:0] CAT_ADJ  = 8'h01;

    localparam int IMM_SYNC_EN = 36;
    localparam int IMM_PWR_LO  = 46;
    localparam int IMM_PWR_HI  = 47;

    localparam logic [PAYLOAD_W-1:0] IMM_MASK =
        (PAYLOAD_W'(1) << IMM_SYNC_EN) |
        (PAYLOAD_W'(1) << IMM_PWR_LO)  |
        (PAYLOAD_W'(1) << IMM_PWR_HI);

    typedef struct packed {
        logic [PAYLOAD_W-1:0] ctrl;
        logic [PAYLOAD_W-1:0] adj;
        logic [PAYLOAD_W-1:0] pend;
        logic                 pend_adj;
        logic                 pend_vld;
        logic                 load_ok;
    } loader_st_t;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    input  logic sclk_i,
    input  logic strb_i,
    input  logic hs_i,
    output logic data_o,
    output logic strb_o,
    output logic sclk_rise_o,
    output logic strb_rise_o,
    output logic strb_fall_o,
    output logic hs_fall_o
);
    localparam int W = 4;

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];
    logic [2:0]   prev_d, prev_q;
    logic [W-1:0] last;

    always_comb begin
        chain_d[0] = {hs_i, strb_i, sclk_i, data_i};
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
        last   = chain_q[STAGES-1];
        prev_d = last[3:1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 4'b1110;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 3'b110;
        else        prev_q <= prev_d;
    end

    assign data_o      = last[0];
    assign strb_o      = last[2];
    assign sclk_rise_o = last[1] & ~prev_q[0];
    assign strb_rise_o = last[2] & ~prev_q[1];
    assign strb_fall_o = ~last[2] & prev_q[1];
    assign hs_fall_o   = ~last[3] & prev_q[2];
endmodule

// File: rtl/scl_frame_shifter.sv
module scl_frame_shifter #(
    parameter int W  = 72,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          shift_i,
    input  logic          bit_i,
    output logic [W-1:0]  frame_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] CNT_MAX = CW'(W + 1);

    logic [W-1:0]  sr_d, sr_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        sr_d  = sr_q;
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (shift_i) begin
            sr_d = {bit_i, sr_q[W-1:1]};
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            sr_q  <= sr_d;
            cnt_q <= cnt_d;
        end
    end

    assign frame_o = sr_q;
    assign count_o = cnt_q;

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
endmodule

// File: rtl/scl_frame_check.sv
module scl_frame_check
    import scl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHIP_ID = 8'h81
) (
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [CNT_W-1:0]      count_i,
    input  logic                  bypass_i,
    output logic                  ok_o,
    output logic                  is_adj_o
);
    logic [BYTE_W-1:0] bytes [NUM_BYTES];
    logic [BYTE_W-1:0] sum;
    logic              id_ok, cat_ok, len_ok, sum_ok;

    generate
        for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
            assign bytes[b] = frame_i[b*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int b = 0; b < NUM_BYTES; b++) sum = sum + bytes[b];
        id_ok    = (bytes[0] == CHIP_ID);
        cat_ok   = (bytes[1] == CAT_CTRL) || (bytes[1] == CAT_ADJ);
        len_ok   = (count_i == CNT_W'(FRAME_BITS));
        sum_ok   = (sum == '0) || bypass_i;
        is_adj_o = (bytes[1] == CAT_ADJ);
        ok_o     = id_ok && cat_ok && len_ok && sum_ok;
    end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHIP_ID     = 8'h81,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_data,
    input  logic                 ser_clk,
    input  logic                 ser_strobe,
    input  logic                 cksum_bypass,
    input  logic                 hsync,
    input  logic                 readout_line,
    input  logic                 long_expose,
    output logic [PAYLOAD_W-1:0] ctrl_bank,
    output logic [PAYLOAD_W-1:0] adj_bank,
    output logic                 load_ok
);
    logic                  data_s, strb_s;
    logic                  sclk_rise, strb_rise, strb_fall, hs_fall;
    logic [FRAME_BITS-1:0] frame;
    logic [CNT_W-1:0]      count;
    logic                  frame_ok, frame_adj;
    logic [PAYLOAD_W-1:0]  payload;
    logic                  commit, clash;
    loader_st_t            st_d, st_q;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .data_i(ser_data), .sclk_i(ser_clk), .strb_i(ser_strobe), .hs_i(hsync),
        .data_o(data_s), .strb_o(strb_s),
        .sclk_rise_o(sclk_rise), .strb_rise_o(strb_rise),
        .strb_fall_o(strb_fall), .hs_fall_o(hs_fall)
    );

    scl_frame_shifter #(.W(FRAME_BITS), .CW(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clr_i(strb_rise | strb_fall),
        .shift_i(sclk_rise & ~strb_s),
        .bit_i(data_s),
        .frame_o(frame), .count_o(count)
    );

    scl_frame_check #(.CHIP_ID(CHIP_ID)) u_check (
        .frame_i(frame), .count_i(count), .bypass_i(cksum_bypass),
        .ok_o(frame_ok), .is_adj_o(frame_adj)
    );

    assign payload = frame[FRAME_BITS-1:PAYLOAD_LSB];

    always_comb begin
        st_d         = st_q;
        st_d.load_ok = 1'b0;
        commit       = hs_fall && readout_line && !long_expose && st_q.pend_vld;
        if (commit) begin
            if (st_q.pend_adj) st_d.adj  = st_q.pend;
            else               st_d.ctrl = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        clash = st_d.pend_vld && (st_d.pend_adj != frame_adj);
        if (strb_rise && frame_ok && !clash) begin
            st_d.pend     = payload;
            st_d.pend_adj = frame_adj;
            st_d.pend_vld = 1'b1;
            st_d.load_ok  = 1'b1;
            if (!frame_adj) st_d.ctrl = (st_d.ctrl & ~IMM_MASK) | (payload & IMM_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_bank = st_q.ctrl;
    assign adj_bank  = st_q.adj;
    assign load_ok   = st_q.load_ok;

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> !load_ok);
    p_accept_at_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |-> $past(strb_rise));
    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && !strb_rise) |=> $stable(ctrl_bank));
    p_adj_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_fall |=> $stable(adj_bank));
    p_expose_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        long_expose |=> $stable(adj_bank));
    p_bank_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_vld && !hs_fall) |=> (st_q.pend_vld && $stable(st_q.pend_adj)));
endmodule

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
    localparam logic [55:0] IMM = (56'd1 << 36) | (56'd1 << 46) | (56'd1 << 47);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_strobe = 1'b1;
    logic cksum_bypass = 1'b0, hsync = 1'b1, readout_line = 1'b0, long_expose = 1'b0;
    logic [55:0] ctrl_bank, adj_bank;
    logic load_ok;

    int nchk = 0, nerr = 0, nload = 0, nwide = 0;
    logic prev_ld = 1'b0;
    logic [55:0] exp_ctrl = '0, exp_adj = '0;

    always #4 clk = ~clk;

    serial_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_strobe(ser_strobe), .cksum_bypass(cksum_bypass), .hsync(hsync),
        .readout_line(readout_line), .long_expose(long_expose),
        .ctrl_bank(ctrl_bank), .adj_bank(adj_bank), .load_ok(load_ok)
    );

    always @(negedge clk) begin
        if (load_ok) nload++;
        if (load_ok && prev_ld) nwide++;
        prev_ld = load_ok;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] mk(input logic [7:0] chip, input logic [7:0] cat,
                                       input logic [47:0] d, input logic [7:0] skew);
        logic [63:0] body;
        logic [7:0]  s;
        body = {d, cat, chip};
        s = '0;
        for (int i = 0; i < 8; i++) s = s + body[i*8 +: 8];
        return {8'(-s) + skew, body};
    endfunction

    task automatic send(input logic [71:0] f, input int nbits);
        @(negedge clk) ser_strobe = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_data = (i < 72) ? f[i] : 1'b0;
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        ser_strobe = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic hs_pulse(input logic rd);
        @(negedge clk) readout_line = rd;
        hsync = 1'b1;
        repeat (4) @(negedge clk);
        hsync = 1'b0;
        repeat (8) @(negedge clk);
        readout_line = 1'b0;
        hsync = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check(ctrl_bank == '0, "R10 reset ctrl", 64'(ctrl_bank), 0);
        check(adj_bank == '0, "R10 reset adj", 64'(adj_bank), 0);
        check(nload == 0, "R10 no pulse at reset", 64'(nload), 0);
    endtask

    task automatic t_ctrl_deferred();
        logic [71:0] f;
        int n0;
        n0 = nload;
        f = mk(8'h81, 8'h00, 48'h0000_0A5C_3E21, 8'h00);
        send(f, 72);
        check(nload == n0 + 1, "R1 accept pulse", 64'(nload), 64'(n0 + 1));
        check(ctrl_bank == exp_ctrl, "R6 no write at strobe", 64'(ctrl_bank), 64'(exp_ctrl));
        hs_pulse(1'b0);
        check(ctrl_bank == exp_ctrl, "R6 no write off readout", 64'(ctrl_bank), 64'(exp_ctrl));
        hs_pulse(1'b1);
        exp_ctrl = f[71:16];
        check(ctrl_bank == exp_ctrl, "R6 write at readout sync fall", 64'(ctrl_bank), 64'(exp_ctrl));
    endtask

    task automatic t_immediate();
        logic [71:0] f;
        f = mk(8'h81, 8'h00, 48'hC010_0000_00F0, 8'h00);
        send(f, 72);
        exp_ctrl = (exp_ctrl & ~IMM) | (f[71:16] & IMM);
        check(ctrl_bank == exp_ctrl, "R7 immediate bits at strobe", 64'(ctrl_bank), 64'(exp_ctrl));
        hs_pulse(1'b1);
        exp_ctrl = f[71:16];
        check(ctrl_bank == exp_ctrl, "R7 rest at sync fall", 64'(ctrl_bank), 64'(exp_ctrl));
    endtask

    task automatic t_reject(input logic [71:0] f, input int nbits, input string tag);
        int n0;
        n0 = nload;
        send(f, nbits);
        hs_pulse(1'b1);
        check(nload == n0, {tag, " no pulse"}, 64'(nload), 64'(n0));
        check(ctrl_bank == exp_ctrl && adj_bank == exp_adj, {tag, " banks kept"},
              64'(ctrl_bank ^ adj_bank), 64'(exp_ctrl ^ exp_adj));
    endtask

    task automatic t_bypass();
        logic [71:0] f;
        f = mk(8'h81, 8'h01, 48'h7777_0000_1234, 8'h5A);
        cksum_bypass = 1'b1;
        send(f, 72);
        cksum_bypass = 1'b0;
        hs_pulse(1'b1);
        exp_adj = f[71:16];
        check(adj_bank == exp_adj, "R5 bypass accepts bad sum", 64'(adj_bank), 64'(exp_adj));
    endtask

    task automatic t_adj();
        logic [71:0] f;
        f = mk(8'h81, 8'h01, 48'hFFFF_C000_0001, 8'h00);
        send(f, 72);
        check(adj_bank == exp_adj, "R3 adj deferred", 64'(adj_bank), 64'(exp_adj));
        check(ctrl_bank == exp_ctrl, "R3 ctrl untouched by adj frame", 64'(ctrl_bank), 64'(exp_ctrl));
        hs_pulse(1'b1);
        exp_adj = f[71:16];
        check(adj_bank == exp_adj, "R3 adj written", 64'(adj_bank), 64'(exp_adj));
    endtask

    task automatic t_overwrite();
        logic [71:0] a, b, c;
        int n0;
        a = mk(8'h81, 8'h00, 48'h0000_0000_1111, 8'h00);
        b = mk(8'h81, 8'h00, 48'h0000_0000_2222, 8'h00);
        send(a, 72);
        send(b, 72);
        hs_pulse(1'b1);
        exp_ctrl = b[71:16];
        check(ctrl_bank == exp_ctrl, "R8 second frame replaces", 64'(ctrl_bank), 64'(exp_ctrl));
        c = mk(8'h81, 8'h01, 48'h0000_0000_3333, 8'h00);
        send(a, 72);
        n0 = nload;
        send(c, 72);
        check(nload == n0, "R8 other bank locked out", 64'(nload), 64'(n0));
        hs_pulse(1'b1);
        exp_ctrl = a[71:16];
        check(ctrl_bank == exp_ctrl, "R8 pending bank written", 64'(ctrl_bank), 64'(exp_ctrl));
        check(adj_bank == exp_adj, "R8 adj unchanged", 64'(adj_bank), 64'(exp_adj));
    endtask

    task automatic t_expose();
        logic [71:0] f;
        f = mk(8'h81, 8'h01, 48'h0000_ABCD_0000, 8'h00);
        send(f, 72);
        long_expose = 1'b1;
        hs_pulse(1'b1);
        check(adj_bank == exp_adj, "R9 blocked in exposure", 64'(adj_bank), 64'(exp_adj));
        long_expose = 1'b0;
        hs_pulse(1'b1);
        exp_adj = f[71:16];
        check(adj_bank == exp_adj, "R9 written after exposure", 64'(adj_bank), 64'(exp_adj));
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_ctrl_deferred();
        t_immediate();
        t_reject(mk(8'h82, 8'h00, 48'hFFFF_FFFF_FFFF, 8'h00), 72, "R2 bad chip id");
        t_reject(mk(8'h81, 8'h00, 48'hFFFF_FFFF_FFFF, 8'h01), 72, "R4 bad checksum");
        t_reject(mk(8'h81, 8'h02, 48'hFFFF_FFFF_FFFF, 8'h00), 72, "R3 bad category");
        t_reject(mk(8'h81, 8'h00, 48'hFFFF_FFFF_FFFF, 8'h00), 71, "R1 short frame");
        t_reject(mk(8'h81, 8'h00, 48'hFFFF_FFFF_FFFF, 8'h00), 73, "R1 long frame");
        t_bypass();
        t_adj();
        t_overwrite();
        t_expose();
        check(nwide == 0, "R10 pulse one cycle", 64'(nwide), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule